// File: doc/BRIEF.md
# NAND Hamming ECC Syndrome Corrector

This block checks the parity code that was read back alongside a 256-byte flash data chunk against the code freshly computed over that same chunk. It XORs the two 22-bit codes into a syndrome and sorts the outcome into one of four classes. The classes are clean, a corrupted stored code, a correctable single data bit, and an uncorrectable pattern. For the correctable class it reports which byte of the chunk and which bit inside that byte are wrong.

A page of 512 bytes is treated as two independent 256-byte chunks, each with its own pair of codes and its own result. A page-mode input says whether the second chunk takes part. After a classification, software or a DMA engine passes data bytes through a small read-modify-write port. The port flips the failing bit when the byte address and chunk match a correctable result. All other bytes pass through unchanged.

Each code arrives as a 22-bit field. It is built from three bytes read in little-endian order, with the first byte in bits [7:0], and the two unused top bits are dropped. Chunk g uses bits [22g+21:22g] of the code buses.

Top module: `ecc_syn_top`

## Requirements
- R1: The status encoding per chunk is 0 = clean, 1 = stored code corrupted, 2 = correctable, 3 = uncorrectable. Chunk g's status is in status_o[2g+1:2g].
- R2: A chunk reports clean (0) when its syndrome (computed XOR stored) is zero, or when either its computed or its stored code is entirely zero.
- R3: A syndrome with exactly one bit set reports stored-code corrupted (1). Any other result is reported only when no rule with higher priority applies, in the order R2, R3, R4, R5.
- R4: A chunk reports correctable (2) when the syndrome has exactly 11 ones and its lower 11 bits are the bitwise complement of its upper 11 bits. In that case the byte index is syndrome bits [10:3] and the bit index is syndrome bits [2:0].
- R5: Every other nonzero syndrome reports uncorrectable (3).
- R6: With page_mode_i low, every chunk except chunk 0 reports clean whatever its codes are. With page_mode_i high, each chunk is classified from its own codes only.
- R7: Results are registered on the rising edge where start_i is high, and done_o is high for exactly the following cycle. Status, byte index and bit index then hold until the next start.
- R8: When fix_en_i is high and the chunk chosen by fix_sel_i is correctable with a byte index equal to fix_addr_i, then on the next cycle fix_valid_o is high and fix_data_o equals fix_data_i with the reported bit inverted.
- R9: For every other fix request, fix_data_o returns fix_data_i unchanged. This covers a chunk that is not correctable and an address that does not match.
- R10: While reset is asserted, and right after it, status, indices, done_o and fix_valid_o are all zero. For any chunk that is not correctable, the byte index and bit index read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Classify strobe |
| page_mode_i | input | 1 | High: all chunks active; low: chunk 0 only |
| calc_i | input | CHUNKS*22 | Freshly computed codes, one 22-bit field per chunk |
| stored_i | input | CHUNKS*22 | Codes read back from the spare area |
| done_o | output | 1 | One-cycle pulse after start_i |
| status_o | output | CHUNKS*2 | Per-chunk class (R1) |
| byte_idx_o | output | CHUNKS*8 | Per-chunk failing byte index |
| bit_idx_o | output | CHUNKS*3 | Per-chunk failing bit index |
| fix_en_i | input | 1 | Read-modify-write request |
| fix_sel_i | input | log2(CHUNKS) | Chunk that the request belongs to |
| fix_addr_i | input | 8 | Byte offset of the presented byte in its chunk |
| fix_data_i | input | 8 | Byte to repair |
| fix_valid_o | output | 1 | Repaired byte valid |
| fix_data_o | output | 8 | Repaired byte |

## Verification
Every cycle, the assertions check the start-to-done timing, that results hold between starts, and that a zero code forces clean. They also check that a disabled second chunk stays clean, that non-correctable chunks show zero indices, and that a repaired byte differs from its input in at most one bit. A byte is checked to come back untouched when its chunk is not correctable or its address misses. Whether the classification is right for a given syndrome can only be shown by the bench's scenarios. These cover single-bit, complementary 11-bit, non-complementary 11-bit and two-bit syndromes, and both page modes. The bench scenarios also show that the correct bit of the correct byte is flipped.

// File: rtl/ecc_syn_pkg.sv
package ecc_syn_pkg;
  typedef enum logic [1:0] {
    SYN_CLEAN    = 2'd0,
    SYN_CODE_BAD = 2'd1,
    SYN_FIXABLE  = 2'd2,
    SYN_FATAL    = 2'd3
  } syn_status_e;
endpackage

// File: rtl/ecc_syn_rstsync.sv
module ecc_syn_rstsync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/ecc_syn_classify.sv
module ecc_syn_classify
  import ecc_syn_pkg::*;
#(
  parameter int CODE_W = 22
) (
  input  logic [CODE_W-1:0]   calc_i,
  input  logic [CODE_W-1:0]   stored_i,
  output syn_status_e         status_o,
  output logic [CODE_W/2-1:0] loc_o
);
  localparam int HALF  = CODE_W / 2;
  localparam int CNT_W = $clog2(CODE_W + 1);

  logic [CODE_W-1:0] syn;
  logic [CNT_W-1:0]  ones;
  logic [HALF-1:0]   pair_chk;

  always_comb begin
    syn  = calc_i ^ stored_i;
    ones = '0;
    for (int i = 0; i < CODE_W; i++) ones = ones + CNT_W'(syn[i]);
    pair_chk = (calc_i[HALF-1:0] ^ calc_i[CODE_W-1:HALF]) ^
               (stored_i[HALF-1:0] ^ stored_i[CODE_W-1:HALF]);
    loc_o = syn[HALF-1:0];
    if (syn == '0 || calc_i == '0 || stored_i == '0)
      status_o = SYN_CLEAN;
    else if (ones == CNT_W'(1))
      status_o = SYN_CODE_BAD;
    else if (ones == CNT_W'(HALF) && (&pair_chk))
      status_o = SYN_FIXABLE;
    else
      status_o = SYN_FATAL;
  end
endmodule

// File: rtl/ecc_syn_fixer.sv
module ecc_syn_fixer #(
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic                      fixable_i,
  input  logic [IDX_W-1:0]          loc_byte_i,
  input  logic [$clog2(BYTE_W)-1:0] loc_bit_i,
  input  logic [IDX_W-1:0]          addr_i,
  input  logic [BYTE_W-1:0]         data_i,
  output logic                      valid_o,
  output logic [BYTE_W-1:0]         data_o
);
  logic [BYTE_W-1:0] mask;
  logic [BYTE_W-1:0] data_d, data_q;
  logic              valid_q;

  always_comb begin
    mask   = (fixable_i && addr_i == loc_byte_i) ? (BYTE_W'(1) << loc_bit_i) : '0;
    data_d = data_i ^ mask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= en_i;
      if (en_i) data_q <= data_d;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
endmodule

// File: rtl/ecc_syn_top.sv
module ecc_syn_top
  import ecc_syn_pkg::*;
#(
  parameter int CHUNKS = 2,
  parameter int CODE_W = 22
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              start_i,
  input  logic                              page_mode_i,
  input  logic [CHUNKS*CODE_W-1:0]          calc_i,
  input  logic [CHUNKS*CODE_W-1:0]          stored_i,
  output logic                              done_o,
  output logic [CHUNKS*2-1:0]               status_o,
  output logic [CHUNKS*(CODE_W/2-3)-1:0]    byte_idx_o,
  output logic [CHUNKS*3-1:0]               bit_idx_o,
  input  logic                              fix_en_i,
  input  logic [$clog2(CHUNKS)-1:0]         fix_sel_i,
  input  logic [CODE_W/2-4:0]               fix_addr_i,
  input  logic [7:0]                        fix_data_i,
  output logic                              fix_valid_o,
  output logic [7:0]                        fix_data_o
);
  localparam int HALF  = CODE_W / 2;
  localparam int IDX_W = HALF - 3;

  logic rst_n;
  logic done_q;
  logic [1:0]       st_all   [CHUNKS];
  logic [IDX_W-1:0] byte_all [CHUNKS];
  logic [2:0]       bit_all  [CHUNKS];

  ecc_syn_rstsync u_rst (.clk_i(clk_i), .rst_ni(rst_ni), .rst_no(rst_n));

  for (genvar g = 0; g < CHUNKS; g++) begin : g_chunk
    syn_status_e     cls_st;
    logic [HALF-1:0] cls_loc;
    logic            active;
    logic [1:0]      st_d, st_q;
    logic [HALF-1:0] loc_d, loc_q;

    ecc_syn_classify #(.CODE_W(CODE_W)) u_cls (
      .calc_i   (calc_i[g*CODE_W +: CODE_W]),
      .stored_i (stored_i[g*CODE_W +: CODE_W]),
      .status_o (cls_st),
      .loc_o    (cls_loc)
    );

    always_comb begin
      active = (g == 0) || page_mode_i;
      st_d   = active ? cls_st : SYN_CLEAN;
      loc_d  = (active && cls_st == SYN_FIXABLE) ? cls_loc : '0;
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) begin
        st_q  <= '0;
        loc_q <= '0;
      end else if (start_i) begin
        st_q  <= st_d;
        loc_q <= loc_d;
      end
    end

    assign st_all[g]   = st_q;
    assign byte_all[g] = loc_q[HALF-1:3];
    assign bit_all[g]  = loc_q[2:0];
    assign status_o[g*2 +: 2]           = st_q;
    assign byte_idx_o[g*IDX_W +: IDX_W] = loc_q[HALF-1:3];
    assign bit_idx_o[g*3 +: 3]          = loc_q[2:0];
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= start_i;
  end
  assign done_o = done_q;

  ecc_syn_fixer #(.BYTE_W(8), .IDX_W(IDX_W)) u_fix (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .en_i       (fix_en_i),
    .fixable_i  (st_all[fix_sel_i] == SYN_FIXABLE),
    .loc_byte_i (byte_all[fix_sel_i]),
    .loc_bit_i  (bit_all[fix_sel_i]),
    .addr_i     (fix_addr_i),
    .data_i     (fix_data_i),
    .valid_o    (fix_valid_o),
    .data_o     (fix_data_o)
  );
endmodule

// File: rtl/ecc_syn_chk.sv
module ecc_syn_chk #(
  parameter int CHUNKS = 2,
  parameter int CODE_W = 22
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           start_i,
  input logic                           page_mode_i,
  input logic [CHUNKS*CODE_W-1:0]       calc_i,
  input logic [CHUNKS*CODE_W-1:0]       stored_i,
  input logic                           done_o,
  input logic [CHUNKS*2-1:0]            status_o,
  input logic [CHUNKS*(CODE_W/2-3)-1:0] byte_idx_o,
  input logic [CHUNKS*3-1:0]            bit_idx_o,
  input logic                           fix_en_i,
  input logic [$clog2(CHUNKS)-1:0]      fix_sel_i,
  input logic [CODE_W/2-4:0]            fix_addr_i,
  input logic [7:0]                     fix_data_i,
  input logic                           fix_valid_o,
  input logic [7:0]                     fix_data_o
);
  localparam int IDX_W = CODE_W / 2 - 3;

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);
  // R7
  done_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(start_i));
  // R7
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(status_o) && $stable(byte_idx_o) && $stable(bit_idx_o)));
  // R2
  zero_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (calc_i[CODE_W-1:0] == '0 || stored_i[CODE_W-1:0] == '0))
      |=> status_o[1:0] == 2'd0);
  // R6
  half_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !page_mode_i) |=> status_o[CHUNKS*2-1:2] == '0);
  // R10
  idle_index_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[1:0] != 2'd2) |-> (byte_idx_o[IDX_W-1:0] == '0 && bit_idx_o[2:0] == '0));
  // R8
  fix_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fix_valid_o |-> $past(fix_en_i));
  // R8
  fix_onebit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fix_valid_o |-> $countones(fix_data_o ^ $past(fix_data_i)) <= 1);
  // R9
  fix_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fix_valid_o && $past(fix_sel_i) == '0 &&
     ($past(status_o[1:0]) != 2'd2 || $past(fix_addr_i) != $past(byte_idx_o[IDX_W-1:0])))
      |-> fix_data_o == $past(fix_data_i));
endmodule

bind ecc_syn_top ecc_syn_chk #(.CHUNKS(CHUNKS), .CODE_W(CODE_W)) u_chk (.*);

// File: tb/ecc_syn_top_tb_top.sv
module ecc_syn_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        page_mode = 1'b1;
  logic [43:0] calc = '0;
  logic [43:0] stored = '0;
  logic        done;
  logic [3:0]  status;
  logic [15:0] byte_idx;
  logic [5:0]  bit_idx;
  logic        fix_en = 1'b0;
  logic [0:0]  fix_sel = '0;
  logic [7:0]  fix_addr = '0;
  logic [7:0]  fix_data = '0;
  logic        fix_valid;
  logic [7:0]  fix_out;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  typedef struct {
    logic [3:0]  st;
    logic [15:0] by;
    logic [5:0]  bi;
    string       tag;
  } cls_item_t;
  typedef struct {
    logic [7:0] val;
    string      tag;
  } fix_item_t;

  cls_item_t cls_q[$];
  fix_item_t fix_q[$];

  always #2 clk = ~clk;

  ecc_syn_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .page_mode_i(page_mode),
    .calc_i(calc), .stored_i(stored), .done_o(done), .status_o(status),
    .byte_idx_o(byte_idx), .bit_idx_o(bit_idx), .fix_en_i(fix_en),
    .fix_sel_i(fix_sel), .fix_addr_i(fix_addr), .fix_data_i(fix_data),
    .fix_valid_o(fix_valid), .fix_data_o(fix_out)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected class of one chunk, written from R2..R6
  task automatic model(input logic [21:0] c, input logic [21:0] s, input bit active,
                       output logic [1:0] st, output logic [7:0] by, output logic [2:0] bi);
    logic [21:0] x;
    int n;
    x = c ^ s; n = 0; by = 8'h00; bi = 3'd0;
    for (int i = 0; i < 22; i++) if (x[i]) n++;
    if (!active || x == 0 || c == 0 || s == 0) st = 2'd0;
    else if (n == 1) st = 2'd1;
    else if (n == 11 && x[10:0] == ~x[21:11]) begin
      st = 2'd2; by = x[10:3]; bi = x[2:0];
    end else st = 2'd3;
  endtask

  task automatic classify(input logic [21:0] c0, input logic [21:0] s0,
                          input logic [21:0] c1, input logic [21:0] s1,
                          input bit pm, input string tag);
    cls_item_t it;
    logic [1:0] st0, st1;
    logic [7:0] by0, by1;
    logic [2:0] bi0, bi1;
    model(c0, s0, 1'b1, st0, by0, bi0);
    model(c1, s1, pm, st1, by1, bi1);
    it.st = {st1, st0}; it.by = {by1, by0}; it.bi = {bi1, bi0}; it.tag = tag;
    @(negedge clk);
    calc = {c1, c0}; stored = {s1, s0}; page_mode = pm; start = 1'b1;
    cls_q.push_back(it);
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic fix(input bit sel, input logic [7:0] addr, input logic [7:0] data,
                     input logic [7:0] exp, input string tag);
    fix_item_t it;
    it.val = exp; it.tag = tag;
    @(negedge clk);
    fix_en = 1'b1; fix_sel = sel; fix_addr = addr; fix_data = data;
    fix_q.push_back(it);
    @(negedge clk);
    fix_en = 1'b0;
    @(negedge clk);
  endtask

  // Monitor: compares results as they appear
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (cls_q.size() == 0) check(1'b0, "R7 unexpected done", 32'd1, 32'd0);
      else begin
        cls_item_t e;
        e = cls_q.pop_front();
        check(status == e.st, {e.tag, " status"}, 32'(status), 32'(e.st));
        check(byte_idx == e.by, {e.tag, " byte index"}, 32'(byte_idx), 32'(e.by));
        check(bit_idx == e.bi, {e.tag, " bit index"}, 32'(bit_idx), 32'(e.bi));
      end
    end
    if (rst_n && fix_valid) begin
      if (fix_q.size() == 0) check(1'b0, "R8 unexpected fix_valid", 32'd1, 32'd0);
      else begin
        fix_item_t f;
        f = fix_q.pop_front();
        check(fix_out == f.val, f.tag, 32'(fix_out), 32'(f.val));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  localparam logic [21:0] S = 22'h15A3C7;

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(status == 0 && byte_idx == 0 && bit_idx == 0, "R10 status in reset", 32'(status), 32'd0);
    check(done == 0 && fix_valid == 0, "R10 strobes in reset", {30'd0, done, fix_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(status == 0 && done == 0, "R10 after release", 32'(status), 32'd0);

    classify(S, S, S, S, 1'b1, "R2 equal codes");
    classify(22'h0, S, S, 22'h0, 1'b1, "R2 zero code");
    classify(S ^ 22'h000400, S, S ^ 22'h200000, S, 1'b1, "R3 single syndrome bit");
    // R9: chunk 0 is stored-code corrupted; syndrome would point at byte 0x80 bit 0
    fix(1'b0, 8'h80, 8'hAA, 8'hAA, "R9 no flip when not correctable");
    classify(S ^ {~11'h5AB, 11'h5AB}, S, S ^ {11'h7FF, 11'h000}, S, 1'b1, "R4 correctable pair");
    // R8: chunk 0 byte 0xB5 bit 3, chunk 1 byte 0x00 bit 0
    fix(1'b0, 8'hB5, 8'hFF, 8'hF7, "R8 flip bit 3 of byte B5");
    fix(1'b1, 8'h00, 8'h00, 8'h01, "R8 flip bit 0 of chunk 1 byte 0");
    fix(1'b1, 8'h01, 8'h00, 8'h00, "R9 address mismatch");
    classify(S ^ {11'h01F, 11'h03F}, S, S ^ 22'h000003, S, 1'b1, "R5 non-complementary and two-bit");
    classify(S ^ {11'h000, 11'h7FF}, S, S ^ 22'h000010, S, 1'b0, "R6 single-chunk mode");
    // R7: results hold while idle
    repeat (6) @(negedge clk);
    check(status == 4'b0010 && byte_idx == 16'h00FF && bit_idx == 6'o07,
          "R7 hold after idle", {status, byte_idx, bit_idx}, {4'b0010, 16'h00FF, 6'o07});
    fix(1'b0, 8'hFF, 8'h12, 8'h92, "R8 flip bit 7 of byte FF");
    fix(1'b0, 8'hFE, 8'h12, 8'h12, "R9 neighbour byte untouched");
    fix(1'b1, 8'h00, 8'h55, 8'h55, "R9 inactive chunk untouched");
    classify(S ^ 22'h3FFFFF, S, 22'h3FFFFF, 22'h155555, 1'b1, "R5 all-ones syndrome; R4 clean mix");
    classify(S, 22'h2AAAAA, S ^ {~11'h001, 11'h001}, S, 1'b1, "R1 per-chunk field order");
    repeat (4) @(negedge clk);
    check(cls_q.size() == 0, "R7 every start produced done", cls_q.size(), 32'd0);
    check(fix_q.size() == 0, "R8 every request produced valid", fix_q.size(), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule